// File: doc/BRIEF.md
# Colour Look-up Table Host Access Port

This block sits between a byte-wide host register interface and a 256-entry colour look-up table. Each table entry holds a red, a green and a blue byte. The host reaches an entry through one data register. It first loads a pointer, then moves the three colour bytes one after another. After every finished triple the pointer moves on by itself, so a run of adjacent entries needs only data accesses. Reads and writes keep separate pointers.

A second, smaller bank holds four more colours: the border (overscan) colour and three cursor colours. The host reaches this bank through its own pair of pointers and its own data register, using the same byte order. On the display side, a pixel index is ANDed with a host-programmed mask, then looks up the table through a synchronous read port. That lookup always takes the shared read port ahead of the host. A mode input selects full 8-bit colour bytes or 6-bit colour bytes.

Top module: `clut_host_port`

## Requirements
- R1: A write to register 0 (table write pointer) followed by three writes to register 2 (table data) stores red, green and blue, in that order, into the addressed entry. The entry is written as a whole on the blue byte.
- R2: After each blue byte is written, the table write pointer advances by one and wraps from 255 to 0.
- R3: A write to register 1 (table read pointer) followed by host reads of register 2 returns red, green and blue in that order. The read pointer advances by one after each blue byte is read.
- R4: The lookup address is the pixel index ANDed with the 8-bit mask in register 3. The mask resets to 0xFF and is repeated over every byte of a wider index.
- R5: Registers 4, 5 and 6 are the write pointer, read pointer and data register of the extra bank. Slot 0 is overscan and slots 1, 2 and 3 are cursor colours 0, 1 and 2. The bank uses the same byte order and a 2-bit wrapping pointer. Slot k appears on `aux_colors[24k+23:24k]` as {red, green, blue}.
- R6: With `dac_8bit` low, data-register readback clears the top two bits of each byte, and each byte of the lookup result is shifted left by two. Stored values are never altered.
- R7: Writing any pointer register returns that pointer's byte sequence to red.
- R8: A triple that is cut short by a pointer write leaves the target entry unchanged.
- R9: A lookup presented with `pix_valid` appears on `pix_rgb` with `pix_out_valid` one cycle later. `pix_rgb` is zero when `pix_out_valid` is low.
- R10: A host read of register 2 in a cycle with `pix_valid` high raises `host_stall` and is not taken. Any taken read gives `host_rvalid` and `host_rdata` in the next cycle.
- R11: After reset, every pointer reads 0, the mask reads 0xFF, every extra colour is 0, and both valid outputs are low.
- R12: Reading a pointer register returns that pointer's current value. Register 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 3 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read request |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read response, one cycle after a taken read |
| host_stall | output | 1 | Host read held off by a lookup this cycle |
| dac_8bit | input | 1 | 1: 8-bit colour bytes, 0: 6-bit colour bytes |
| pix_valid | input | 1 | Lookup request |
| pix_index | input | 8 | Lookup pixel index |
| pix_out_valid | output | 1 | Lookup result valid |
| pix_rgb | output | 24 | Lookup result {red, green, blue} |
| aux_colors | output | 96 | Overscan and cursor colours, slot 0 lowest |

## Verification
The bench builds the block with its default 8-bit index, so the whole 256-entry table is filled and checked. With that size, the write-pointer wrap from 255 to 0 takes only one pointer load, and the four-slot extra bank wraps after two triples. The 8-bit mask width equals the index width, so every mask bit is exercised by random lookups.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int CH_W   = 8;
    localparam int RGB_W  = 3 * CH_W;
    localparam int AUX_N  = 4;
    localparam int AUX_AW = 2;
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        PH_R = 2'd0,
        PH_G = 2'd1,
        PH_B = 2'd2
    } phase_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_PAL_WA  = 3'd0,
        SEL_PAL_RA  = 3'd1,
        SEL_PAL_DAT = 3'd2,
        SEL_MASK    = 3'd3,
        SEL_AUX_WA  = 3'd4,
        SEL_AUX_RA  = 3'd5,
        SEL_AUX_DAT = 3'd6,
        SEL_NONE    = 3'd7
    } sel_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // select one colour byte by sequence phase
    function automatic logic [CH_W-1:0] pick_byte(rgb_t c, phase_e p);
        case (p)
            PH_R:    return c.r;
            PH_G:    return c.g;
            default: return c.b;
        endcase
    endfunction

    // readback view of a byte: upper two bits cleared in narrow mode
    function automatic logic [CH_W-1:0] trim_byte(logic [CH_W-1:0] v, logic wide);
        logic [CH_W-1:0] keep;
        keep = {2'b00, {(CH_W-2){1'b1}}};
        return wide ? v : (v & keep);
    endfunction

    // lookup view of an entry: bytes moved up by two in narrow mode
    function automatic rgb_t widen(rgb_t c, logic wide);
        rgb_t o;
        o = c;
        if (!wide) begin
            o.r = c.r << 2;
            o.g = c.g << 2;
            o.b = c.b << 2;
        end
        return o;
    endfunction

endpackage

// File: rtl/triple_writer.sv
module triple_writer
    import clut_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [AW-1:0]   load_addr,
    input  logic            wr,
    input  logic [CH_W-1:0] wdata,
    output logic            commit,
    output logic [AW-1:0]   addr,
    output rgb_t            entry
);

    logic [AW-1:0]   addr_q;
    phase_e          phase_q;
    logic [CH_W-1:0] red_q;
    logic [CH_W-1:0] grn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            phase_q <= PH_R;
            red_q   <= '0;
            grn_q   <= '0;
        end else if (load) begin
            addr_q  <= load_addr;
            phase_q <= PH_R;
        end else if (wr) begin
            case (phase_q)
                PH_R: begin
                    red_q   <= wdata;
                    phase_q <= PH_G;
                end
                PH_G: begin
                    grn_q   <= wdata;
                    phase_q <= PH_B;
                end
                default: begin
                    addr_q  <= addr_q + 1'b1;
                    phase_q <= PH_R;
                end
            endcase
        end
    end

    assign commit = wr && !load && (phase_q == PH_B);
    assign addr   = addr_q;
    assign entry  = '{r: red_q, g: grn_q, b: wdata};

endmodule

// File: rtl/triple_reader.sv
module triple_reader
    import clut_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] addr,
    output phase_e        phase
);

    logic [AW-1:0] addr_q;
    phase_e        phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            phase_q <= PH_R;
        end else if (load) begin
            addr_q  <= load_addr;
            phase_q <= PH_R;
        end else if (step) begin
            case (phase_q)
                PH_R:    phase_q <= PH_G;
                PH_G:    phase_q <= PH_B;
                default: begin
                    phase_q <= PH_R;
                    addr_q  <= addr_q + 1'b1;
                end
            endcase
        end
    end

    assign addr  = addr_q;
    assign phase = phase_q;

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rgb_t          wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output rgb_t          q
);

    localparam int DEPTH = 1 << AW;

    rgb_t mem [DEPTH];
    rgb_t q_r;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (re) begin
            q_r <= mem[raddr];
        end
    end

    assign q = q_r;

endmodule

// File: rtl/aux_bank.sv
module aux_bank
    import clut_pkg::*;
#(
    parameter int N  = AUX_N,
    parameter int AW = AUX_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  rgb_t             wdata,
    input  logic [AW-1:0]    raddr,
    output rgb_t             rdata,
    output logic [N*RGB_W-1:0] flat
);

    rgb_t slot [N];

    for (genvar k = 0; k < N; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[k] <= '0;
            end else if (we && (waddr == AW'(k))) begin
                slot[k] <= wdata;
            end
        end
        assign flat[k*RGB_W +: RGB_W] = slot[k];
    end

    assign rdata = slot[raddr];

endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SEL_W-1:0]       host_sel,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic [CH_W-1:0]        host_wdata,
    output logic [CH_W-1:0]        host_rdata,
    output logic                   host_rvalid,
    output logic                   host_stall,
    input  logic                   dac_8bit,
    input  logic                   pix_valid,
    input  logic [IDX_W-1:0]       pix_index,
    output logic                   pix_out_valid,
    output logic [RGB_W-1:0]       pix_rgb,
    output logic [AUX_N*RGB_W-1:0] aux_colors
);

    sel_e sel;
    assign sel = sel_e'(host_sel);

    // host decode
    logic pal_wload, pal_wdat, pal_rload, mask_wr;
    logic aux_wload, aux_wdat, aux_rload;
    logic host_acc, pal_step, aux_step;

    assign pal_wload = host_wr && (sel == SEL_PAL_WA);
    assign pal_rload = host_wr && (sel == SEL_PAL_RA);
    assign pal_wdat  = host_wr && (sel == SEL_PAL_DAT);
    assign mask_wr   = host_wr && (sel == SEL_MASK);
    assign aux_wload = host_wr && (sel == SEL_AUX_WA);
    assign aux_rload = host_wr && (sel == SEL_AUX_RA);
    assign aux_wdat  = host_wr && (sel == SEL_AUX_DAT);

    assign host_stall = host_rd && pix_valid && (sel == SEL_PAL_DAT);
    assign host_acc   = host_rd && !host_stall;
    assign pal_step   = host_acc && (sel == SEL_PAL_DAT);
    assign aux_step   = host_acc && (sel == SEL_AUX_DAT);

    // pixel mask, repeated over the index
    logic [CH_W-1:0]  mask_q;
    logic [IDX_W-1:0] mask_rep;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_wr) begin
            mask_q <= host_wdata;
        end
    end

    for (genvar i = 0; i < IDX_W; i++) begin : g_mask
        assign mask_rep[i] = mask_q[i % CH_W];
    end

    // table side
    logic [IDX_W-1:0] pal_waddr, pal_raddr, store_raddr;
    logic             pal_commit, store_re;
    rgb_t             pal_entry, store_q;
    phase_e           pal_rphase;

    triple_writer #(.AW(IDX_W)) u_pal_wr (
        .clk      (clk),
        .rst      (rst),
        .load     (pal_wload),
        .load_addr(IDX_W'(host_wdata)),
        .wr       (pal_wdat),
        .wdata    (host_wdata),
        .commit   (pal_commit),
        .addr     (pal_waddr),
        .entry    (pal_entry)
    );

    triple_reader #(.AW(IDX_W)) u_pal_rd (
        .clk      (clk),
        .rst      (rst),
        .load     (pal_rload),
        .load_addr(IDX_W'(host_wdata)),
        .step     (pal_step),
        .addr     (pal_raddr),
        .phase    (pal_rphase)
    );

    assign store_re    = pix_valid || pal_step;
    assign store_raddr = pix_valid ? (pix_index & mask_rep) : pal_raddr;

    clut_store #(.AW(IDX_W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (pal_commit),
        .waddr(pal_waddr),
        .wdata(pal_entry),
        .re   (store_re),
        .raddr(store_raddr),
        .q    (store_q)
    );

    // extra colour bank
    logic [AUX_AW-1:0] aux_waddr, aux_raddr;
    logic              aux_commit;
    rgb_t              aux_entry, aux_rdata;
    phase_e            aux_rphase;

    triple_writer #(.AW(AUX_AW)) u_aux_wr (
        .clk      (clk),
        .rst      (rst),
        .load     (aux_wload),
        .load_addr(AUX_AW'(host_wdata)),
        .wr       (aux_wdat),
        .wdata    (host_wdata),
        .commit   (aux_commit),
        .addr     (aux_waddr),
        .entry    (aux_entry)
    );

    triple_reader #(.AW(AUX_AW)) u_aux_rd (
        .clk      (clk),
        .rst      (rst),
        .load     (aux_rload),
        .load_addr(AUX_AW'(host_wdata)),
        .step     (aux_step),
        .addr     (aux_raddr),
        .phase    (aux_rphase)
    );

    aux_bank #(.N(AUX_N), .AW(AUX_AW)) u_aux (
        .clk  (clk),
        .rst  (rst),
        .we   (aux_commit),
        .waddr(aux_waddr),
        .wdata(aux_entry),
        .raddr(aux_raddr),
        .rdata(aux_rdata),
        .flat (aux_colors)
    );

    // read response
    logic [CH_W-1:0] other_val, other_q;
    logic            rvalid_q, src_pal_q, mode_q;
    phase_e          bsel_q;
    logic            pix_vld_q, pix_mode_q;

    always_comb begin
        case (sel)
            SEL_PAL_WA:  other_val = CH_W'(pal_waddr);
            SEL_PAL_RA:  other_val = CH_W'(pal_raddr);
            SEL_MASK:    other_val = mask_q;
            SEL_AUX_WA:  other_val = CH_W'(aux_waddr);
            SEL_AUX_RA:  other_val = CH_W'(aux_raddr);
            SEL_AUX_DAT: other_val = trim_byte(pick_byte(aux_rdata, aux_rphase), dac_8bit);
            default:     other_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q   <= 1'b0;
            src_pal_q  <= 1'b0;
            mode_q     <= 1'b1;
            bsel_q     <= PH_R;
            other_q    <= '0;
            pix_vld_q  <= 1'b0;
            pix_mode_q <= 1'b1;
        end else begin
            rvalid_q   <= host_acc;
            pix_vld_q  <= pix_valid;
            pix_mode_q <= dac_8bit;
            if (host_acc) begin
                src_pal_q <= (sel == SEL_PAL_DAT);
                bsel_q    <= pal_rphase;
                mode_q    <= dac_8bit;
                other_q   <= other_val;
            end
        end
    end

    assign host_rvalid   = rvalid_q;
    assign host_rdata    = src_pal_q ? trim_byte(pick_byte(store_q, bsel_q), mode_q) : other_q;
    assign pix_out_valid = pix_vld_q;
    assign pix_rgb       = pix_vld_q ? widen(store_q, pix_mode_q) : '0;

endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             host_rd,
    input logic [SEL_W-1:0] host_sel,
    input logic             host_stall,
    input logic             host_rvalid,
    input logic [CH_W-1:0]  host_rdata,
    input logic             dac_8bit,
    input logic             pix_valid,
    input logic             pix_out_valid,
    input logic [RGB_W-1:0] pix_rgb,
    input logic             pal_wload,
    input logic [1:0]       pal_wphase,
    input logic             pal_commit,
    input logic [IDX_W-1:0] pal_waddr
);

    // R9
    lookup_lat_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> pix_out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        host_stall |=> !host_rvalid);

    // R10
    accept_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_stall) |=> host_rvalid);

    // R6
    narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_stall && !dac_8bit &&
         (host_sel == 3'd2 || host_sel == 3'd6)) |=> ((host_rdata & 8'hC0) == 8'h00));

    // R6
    narrow_pix_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !dac_8bit) |=> ((pix_rgb & 24'h030303) == 24'h0));

    // R7
    phase_reset_chk: assert property (@(posedge clk) disable iff (rst)
        pal_wload |=> (pal_wphase == 2'd0));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        pal_commit |=> (pal_waddr == IDX_W'($past(pal_waddr) + 1'b1)));

endmodule

bind clut_host_port clut_host_port_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_rd      (host_rd),
    .host_sel     (host_sel),
    .host_stall   (host_stall),
    .host_rvalid  (host_rvalid),
    .host_rdata   (host_rdata),
    .dac_8bit     (dac_8bit),
    .pix_valid    (pix_valid),
    .pix_out_valid(pix_out_valid),
    .pix_rgb      (pix_rgb),
    .pal_wload    (pal_wload),
    .pal_wphase   (u_pal_wr.phase_q),
    .pal_commit   (pal_commit),
    .pal_waddr    (pal_waddr)
);

// File: tb/test_clut_host_port.sv
`timescale 1ns/1ps
module test_clut_host_port;

    localparam int CLK_P = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  host_sel;
    logic        host_wr, host_rd;
    logic [7:0]  host_wdata;
    logic [7:0]  host_rdata;
    logic        host_rvalid, host_stall;
    logic        dac_8bit;
    logic        pix_valid;
    logic [7:0]  pix_index;
    logic        pix_out_valid;
    logic [23:0] pix_rgb;
    logic [95:0] aux_colors;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [23:0] pal_m [256];

    always #(CLK_P / 2.0) clk = ~clk;

    clut_host_port i_clut_host_port (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .host_stall(host_stall),
        .dac_8bit(dac_8bit),
        .pix_valid(pix_valid), .pix_index(pix_index),
        .pix_out_valid(pix_out_valid), .pix_rgb(pix_rgb),
        .aux_colors(aux_colors)
    );

    function automatic logic [23:0] exp_pix(logic [23:0] e, bit wide);
        if (wide) return e;
        return {e[23:16] << 2, e[15:8] << 2, e[7:0] << 2};
    endfunction

    function automatic logic [7:0] exp_byte(logic [23:0] e, int ph, bit wide);
        logic [7:0] v;
        v = (ph == 0) ? e[23:16] : (ph == 1) ? e[15:8] : e[7:0];
        return wide ? v : (v & 8'h3F);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [7:0] d, output logic v);
        @(negedge clk);
        host_sel = s; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata; v = host_rvalid;
    endtask

    task automatic look(input logic [7:0] idx, output logic [23:0] c, output logic v);
        @(negedge clk);
        pix_index = idx; pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        c = pix_rgb; v = pix_out_valid;
    endtask

    task automatic put_rgb(input logic [2:0] s, input logic [23:0] c);
        wr_reg(s, c[23:16]);
        wr_reg(s, c[15:8]);
        wr_reg(s, c[7:0]);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic        v;
        logic [23:0] c;
        void'($urandom(32'h00C1A7));
        rst = 1'b1; host_sel = 3'd7; host_wr = 0; host_rd = 0; host_wdata = 0;
        dac_8bit = 1'b1; pix_valid = 0; pix_index = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 / R12 reset state
        check(host_rvalid == 0 && pix_out_valid == 0, "R11 valids", {host_rvalid, pix_out_valid}, 0);
        check(aux_colors == '0, "R11 aux", aux_colors[31:0], 0);
        rd_reg(3'd0, d, v); check(v && d == 8'h00, "R11 wptr", d, 0);
        rd_reg(3'd1, d, v); check(v && d == 8'h00, "R11 rptr", d, 0);
        rd_reg(3'd3, d, v); check(v && d == 8'hFF, "R11 mask", d, 8'hFF);
        rd_reg(3'd7, d, v); check(v && d == 8'h00, "R12 unused reg", d, 0);

        // fill the whole table (R1, R2)
        wr_reg(3'd0, 8'h00);
        for (int i = 0; i < 256; i++) begin
            pal_m[i] = 24'($urandom);
            put_rgb(3'd2, pal_m[i]);
        end
        rd_reg(3'd0, d, v); check(d == 8'h00, "R2 wrap after fill", d, 0);

        // directed entries 5 and 6 (R1, R2)
        wr_reg(3'd0, 8'd5);
        put_rgb(3'd2, 24'h112233); pal_m[5] = 24'h112233;
        put_rgb(3'd2, 24'h445566); pal_m[6] = 24'h445566;
        rd_reg(3'd0, d, v); check(d == 8'd7, "R2 wptr after two triples", d, 7);
        look(8'd5, c, v); check(v && c == 24'h112233, "R1 entry 5", c, 24'h112233);
        look(8'd6, c, v); check(v && c == 24'h445566, "R2 entry 6", c, 24'h445566);

        // readback (R3)
        wr_reg(3'd1, 8'd5);
        for (int k = 0; k < 6; k++) begin
            rd_reg(3'd2, d, v);
            check(v && d == exp_byte(pal_m[5 + k / 3], k % 3, 1), "R3 readback", d, exp_byte(pal_m[5 + k / 3], k % 3, 1));
        end
        rd_reg(3'd1, d, v); check(d == 8'd7, "R3 rptr advance", d, 7);

        // partial triple (R8) then restart at red (R7)
        wr_reg(3'd0, 8'd6);
        wr_reg(3'd2, 8'hAA); wr_reg(3'd2, 8'hBB);
        wr_reg(3'd0, 8'd6);
        look(8'd6, c, v); check(c == 24'h445566, "R8 partial ignored", c, 24'h445566);
        put_rgb(3'd2, 24'h010203); pal_m[6] = 24'h010203;
        look(8'd6, c, v); check(c == 24'h010203, "R7 sequence restarts at red", c, 24'h010203);
        wr_reg(3'd1, 8'd6); rd_reg(3'd2, d, v);
        wr_reg(3'd1, 8'd6); rd_reg(3'd2, d, v);
        check(d == 8'h01, "R7 read sequence restarts", d, 8'h01);

        // write pointer wrap (R2)
        wr_reg(3'd0, 8'hFF);
        put_rgb(3'd2, 24'hC1D2E3); pal_m[255] = 24'hC1D2E3;
        rd_reg(3'd0, d, v); check(d == 8'h00, "R2 wrap 255 to 0", d, 0);

        // mask (R4)
        wr_reg(3'd3, 8'h0F);
        look(8'hF5, c, v); check(c == pal_m[5], "R4 masked index", c, pal_m[5]);
        wr_reg(3'd3, 8'hFF);

        // narrow mode (R6)
        dac_8bit = 1'b0;
        look(8'hFF, c, v); check(c == 24'h04488C, "R6 lookup shift", c, 24'h04488C);
        wr_reg(3'd1, 8'hFF);
        rd_reg(3'd2, d, v); check(d == 8'h01, "R6 readback red", d, 8'h01);
        rd_reg(3'd2, d, v); check(d == 8'h12, "R6 readback green", d, 8'h12);
        rd_reg(3'd2, d, v); check(d == 8'h23, "R6 readback blue", d, 8'h23);
        dac_8bit = 1'b1;
        look(8'hFF, c, v); check(c == 24'hC1D2E3, "R6 stored value intact", c, 24'hC1D2E3);

        // extra bank (R5)
        wr_reg(3'd4, 8'd1);
        put_rgb(3'd6, 24'hA0A1A2);
        put_rgb(3'd6, 24'hB0B1B2);
        check(aux_colors[24 +: 24] == 24'hA0A1A2, "R5 cursor0", aux_colors[24 +: 24], 24'hA0A1A2);
        check(aux_colors[48 +: 24] == 24'hB0B1B2, "R5 cursor1 auto step", aux_colors[48 +: 24], 24'hB0B1B2);
        wr_reg(3'd4, 8'd3);
        put_rgb(3'd6, 24'hC0C1C2);
        put_rgb(3'd6, 24'hD0D1D2);
        check(aux_colors[72 +: 24] == 24'hC0C1C2, "R5 cursor2", aux_colors[72 +: 24], 24'hC0C1C2);
        check(aux_colors[0 +: 24] == 24'hD0D1D2, "R5 wrap to overscan", aux_colors[0 +: 24], 24'hD0D1D2);
        rd_reg(3'd4, d, v); check(d == 8'd1, "R12 aux wptr", d, 1);
        wr_reg(3'd5, 8'd1);
        rd_reg(3'd2 + 3'd4, d, v); check(d == 8'hA0, "R5 aux read red", d, 8'hA0);
        rd_reg(3'd6, d, v); check(d == 8'hA1, "R5 aux read green", d, 8'hA1);
        rd_reg(3'd6, d, v); check(d == 8'hA2, "R5 aux read blue", d, 8'hA2);
        rd_reg(3'd5, d, v); check(d == 8'd2, "R12 aux rptr", d, 2);

        // collision (R10, R9)
        wr_reg(3'd1, 8'd5);
        @(negedge clk);
        pix_valid = 1'b1; pix_index = 8'd6; host_sel = 3'd2; host_rd = 1'b1;
        #1 check(host_stall == 1'b1, "R10 stall raised", host_stall, 1);
        @(negedge clk);
        pix_valid = 1'b0;
        check(host_rvalid == 1'b0, "R10 stalled read not taken", host_rvalid, 0);
        check(pix_out_valid && pix_rgb == pal_m[6], "R9 lookup wins", pix_rgb, pal_m[6]);
        #1 check(host_stall == 1'b0, "R10 stall released", host_stall, 0);
        @(negedge clk);
        host_rd = 1'b0;
        check(host_rvalid && host_rdata == pal_m[5][23:16], "R10 late read data", host_rdata, pal_m[5][23:16]);
        check(pix_out_valid == 0 && pix_rgb == 0, "R9 idle output zero", pix_rgb, 0);

        // random mix (R1, R3, R4, R6)
        for (int it = 0; it < 120; it++) begin
            int kind;
            kind = int'($urandom % 3);
            if (kind == 0) begin
                logic [7:0] st;
                int n;
                st = 8'($urandom); n = 1 + int'($urandom % 3);
                wr_reg(3'd0, st);
                for (int j = 0; j < n; j++) begin
                    logic [23:0] e;
                    e = 24'($urandom);
                    put_rgb(3'd2, e);
                    pal_m[8'(st + 8'(j))] = e;
                end
            end else if (kind == 1) begin
                logic [7:0] m, ix;
                bit w;
                m = 8'($urandom); ix = 8'($urandom); w = 1'($urandom);
                wr_reg(3'd3, m);
                dac_8bit = w;
                look(ix, c, v);
                check(v && c == exp_pix(pal_m[ix & m], w), "R4 R6 random lookup", c, exp_pix(pal_m[ix & m], w));
                dac_8bit = 1'b1;
                wr_reg(3'd3, 8'hFF);
            end else begin
                logic [7:0] ra;
                bit w;
                ra = 8'($urandom); w = 1'($urandom);
                wr_reg(3'd1, ra);
                dac_8bit = w;
                for (int k = 0; k < 3; k++) begin
                    rd_reg(3'd2, d, v);
                    check(v && d == exp_byte(pal_m[ra], k, w), "R3 R6 random readback", d, exp_byte(pal_m[ra], k, w));
                end
                dac_8bit = 1'b1;
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule